// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is an 8-bit timer that produces a centre-aligned pulse-width-modulated output. Its counter climbs from 0 to 255 and then falls back to 0, one step per prescaled tick, so one waveform period spans 510 ticks. A compare value sets how long the output stays high. The output switches at the compare point on the way up and again at the compare point on the way down, so each pulse is symmetric about the counter's turning point at zero.

Firmware can rewrite the compare value at any moment. The new value reaches the comparator only when the counter turns round at its top value, which keeps every period free of glitches. A polarity input inverts the waveform. A prescaler selector sets the tick rate. As an example, a 16 MHz clock divided by 256 gives an output of about 122.5 Hz.

Top module: `pwm_dual_slope_timer`

## Requirements
- R1: On each tick the count climbs by one from 0 up to 255, turns round and falls by one to 0, then climbs again. Each endpoint appears for exactly one tick, so one period is 510 ticks.
- R2: A tick occurs once every 1, 8, 64 or 256 enabled clock cycles, for `div_sel` equal to 0, 1, 2 or 3. After reset the first tick comes at the last of those cycles.
- R3: While `run` is low, the count and the prescaler phase are held, and no tick occurs.
- R4: With `pol_inv`=0 and an active compare value C, where 0<C<255, the output goes low when the rising count reaches C and goes high when the falling count reaches C. While rising it is high exactly when the count is below C. While falling or at 0 it is high exactly when the count is at most C. This gives 2·C high ticks per 510-tick period.
- R5: With `pol_inv`=1 the output is the exact complement of the R4 level.
- R6: An active compare value of 0 holds the non-inverted output low, and a value of 255 holds it high. In both cases the output has no edges.
- R7: `duty_cmp` is copied into the active compare register only on the tick that moves the count from 255 to 254. A change at any other time has no effect on the output until that tick.
- R8: While `rst` is high: the count is 0, the next step is upward, the active compare value is 0, and `pwm_out` equals `pol_inv`, which is the inactive level.
- R9: `pwm_out` and `count` are registered and change on the same clock edge. Each output level belongs to the count shown in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables the prescaler and the counter |
| div_sel | input | 2 | Tick divider: 0=1, 1=8, 2=64, 3=256 |
| pol_inv | input | 1 | 0 = non-inverting, 1 = inverting output |
| duty_cmp | input | 8 | Compare value that firmware writes, buffered until the top of the count |
| pwm_out | output | 1 | PWM waveform |
| count | output | 8 | Present counter value |

## Verification
The bench uses the default 8-bit counter and the default divider step, so all four tick rates are present. With divide-by-1, a full 510-cycle period costs 510 clock cycles. That speed lets the bench sweep compare values across the whole 0 to 255 range, including both constant-level extremes, and check every cycle against a closed-form triangle position. The slower dividers are checked over their first few ticks. A compare rewrite placed in the middle of a period shows that the buffered value waits for the next turn at 255.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} pwm_dir_e;

  // shift amount for a divider selection, saturated at the prescaler width
  function automatic int unsigned pwm_div_shift(input int unsigned sel,
                                                input int unsigned step,
                                                input int unsigned cap);
    int unsigned s;
    s = sel * step;
    return (s > cap) ? cap : s;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int PRE_W = 8,
  parameter int SEL_W = 2,
  parameter int STEP  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick_o
);
  import pwm_pkg::*;
  localparam int NSEL = 1 << SEL_W;
  localparam logic [PRE_W:0] ONE = {{PRE_W{1'b0}}, 1'b1};

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] mask_tab [NSEL];
  logic [PRE_W-1:0] mask;

  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    localparam int unsigned SH = pwm_div_shift(g, STEP, PRE_W);
    localparam logic [PRE_W:0] FULL = (ONE << SH) - ONE;
    assign mask_tab[g] = FULL[PRE_W-1:0];
  end

  assign mask   = mask_tab[div_sel];
  assign tick_o = run && ((phase_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)      phase_q <= '0;
    else if (run) phase_q <= phase_q + 1'b1;
  end

  p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick_o);
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_sel != '0) |=> (!tick_o || div_sel != $past(div_sel)));
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(phase_q));
endmodule

// File: rtl/pwm_updown.sv
`timescale 1ns/1ps
module pwm_updown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             up_d_o,
  output logic             at_top_o
);
  import pwm_pkg::*;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] BOT = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  pwm_dir_e         dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (tick) begin
      if (dir_q == DIR_UP) begin
        if (cnt_q == TOP) begin
          cnt_d = TOP - 1'b1;
          dir_d = DIR_DOWN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == BOT) begin
          cnt_d = BOT + 1'b1;
          dir_d = DIR_UP;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= BOT;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign cnt_d_o  = cnt_d;
  assign up_d_o   = (dir_d == DIR_UP);
  assign at_top_o = tick && (cnt_q == TOP);

  p_rise_step_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && dir_q == DIR_UP && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_turn_top_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == TOP) |=> (cnt_q == TOP - 1'b1 && dir_q == DIR_DOWN));
  p_turn_bottom_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && dir_q == DIR_DOWN && cnt_q == BOT) |=> (cnt_q == BOT + 1'b1 && dir_q == DIR_UP));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_compare_out.sv
`timescale 1ns/1ps
module pwm_compare_out #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pol_inv,
  input  logic [CNT_W-1:0] duty_cmp,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             up_d,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] ocr_q, ocr_d;
  logic             lvl, pwm_q;

  assign ocr_d = load ? duty_cmp : ocr_q;

  always_comb begin
    if (ocr_d == '0)       lvl = 1'b0;
    else if (ocr_d == TOP) lvl = 1'b1;
    else if (up_d)         lvl = (cnt_d < ocr_d);
    else                   lvl = (cnt_d <= ocr_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr_q <= '0;
      pwm_q <= pol_inv;
    end else begin
      ocr_q <= ocr_d;
      pwm_q <= lvl ^ pol_inv;
    end
  end

  assign pwm_o = pwm_q;

  p_cmp_buffered_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ocr_q));
  p_flat_extremes_r6: assert property (@(posedge clk) disable iff (rst)
    ((ocr_q == '0 || ocr_q == TOP) && !load && $stable(pol_inv)) |=> $stable(pwm_q));
endmodule

// File: rtl/pwm_dual_slope_timer.sv
`timescale 1ns/1ps
module pwm_dual_slope_timer #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2,
  parameter int STEP  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             pol_inv,
  input  logic [CNT_W-1:0] duty_cmp,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count
);
  logic             tick, at_top, up_d;
  logic [CNT_W-1:0] cnt_d;

  pwm_prescaler #(.PRE_W(CNT_W), .SEL_W(SEL_W), .STEP(STEP)) u_pre (
    .clk(clk), .rst(rst), .run(run), .div_sel(div_sel), .tick_o(tick));

  pwm_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt_o(count),
    .cnt_d_o(cnt_d), .up_d_o(up_d), .at_top_o(at_top));

  pwm_compare_out #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .pol_inv(pol_inv), .duty_cmp(duty_cmp),
    .load(at_top), .cnt_d(cnt_d), .up_d(up_d), .pwm_o(pwm_out));
endmodule

// File: tb/pwm_dual_slope_timer_tb.sv
`timescale 1ns/1ps
module pwm_dual_slope_timer_tb;
  localparam int CLK_PER = 10;
  localparam int WD_CYC  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [1:0] div_sel = '0;
  logic       pol_inv = 1'b0;
  logic [7:0] duty_cmp = '0;
  logic       pwm_out;
  logic [7:0] count;

  int checks = 0, errors = 0;
  bit done = 0;
  int e_ph, p_pos, exp_ocr;

  always #(CLK_PER/2) clk = ~clk;

  pwm_dual_slope_timer u_dut (
    .clk(clk), .rst(rst), .run(run), .div_sel(div_sel), .pol_inv(pol_inv),
    .duty_cmp(duty_cmp), .pwm_out(pwm_out), .count(count));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 30) $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ratio_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 64 : 256;
  endfunction

  function automatic int exp_cnt();
    return (p_pos <= 255) ? p_pos : 510 - p_pos;
  endfunction

  function automatic bit exp_pwm();
    bit l;
    int c;
    c = exp_cnt();
    if (exp_ocr == 0)        l = 0;
    else if (exp_ocr == 255) l = 1;
    else if (p_pos <= 255)   l = (c < exp_ocr);
    else                     l = (c <= exp_ocr);
    return l ^ pol_inv;
  endfunction

  task automatic do_reset(input int s, input bit inv, input int c);
    @(negedge clk);
    rst = 1'b1; run = 1'b1; div_sel = 2'(s); pol_inv = inv; duty_cmp = 8'(c);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(count == 8'd0, "R8 count", count, 0);
    chk(pwm_out == inv, "R8 pwm", pwm_out, inv);
    rst = 1'b0;
    e_ph = 0; p_pos = 0; exp_ocr = 0;
  endtask

  // one clock: model advance at the edge, compare at the falling edge
  task automatic step(input string tag);
    @(posedge clk);
    if (run) begin
      if ((e_ph % ratio_of(div_sel)) == ratio_of(div_sel) - 1) begin
        if (p_pos == 255) exp_ocr = duty_cmp;
        p_pos = (p_pos + 1) % 510;
      end
      e_ph = (e_ph + 1) % 256;
    end
    @(negedge clk);
    chk(count == 8'(exp_cnt()), {tag, " count"}, count, exp_cnt());
    chk(pwm_out == exp_pwm(), {tag, " pwm"}, pwm_out, exp_pwm());
  endtask

  task automatic run_n(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    int hi, edges;
    bit last;
    // R8 with both polarities, then R1/R4/R9 at 50% duty
    do_reset(0, 1, 127);
    do_reset(0, 0, 127);
    run_n(510, "R1");
    hi = 0;
    for (int i = 0; i < 510; i++) begin step("R9"); hi += pwm_out; end
    chk(hi == 254, "R4 high ticks", hi, 254);
    run_n(510, "R1");

    // R5 inverting
    do_reset(0, 1, 127);
    run_n(510, "R5");
    hi = 0;
    for (int i = 0; i < 510; i++) begin step("R5"); hi += pwm_out; end
    chk(hi == 510 - 254, "R5 high ticks", hi, 256);

    // R4/R6 sweep of compare values
    for (int c = 0; c < 256; c += 17) begin
      do_reset(0, 0, c);
      run_n(766, "R4");
      hi = 0; edges = 0; last = pwm_out;
      for (int i = 0; i < 510; i++) begin
        step("R4");
        hi += pwm_out;
        if (pwm_out != last) edges++;
        last = pwm_out;
      end
      chk(hi == ((c == 255) ? 510 : 2 * c), "R4 sweep high ticks", hi, (c == 255) ? 510 : 2 * c);
      if (c == 0 || c == 255) chk(edges == 0, "R6 edges", edges, 0);
    end
    for (int c = 1; c < 255; c += 253) begin
      do_reset(0, 0, c);
      run_n(1276, "R4");
    end

    // R7 mid-period rewrite
    do_reset(0, 0, 40);
    run_n(300, "R7");
    duty_cmp = 8'd200;
    run_n(400, "R7");
    chk(exp_ocr == 40, "R7 not yet loaded", exp_ocr, 40);
    run_n(600, "R7");
    chk(exp_ocr == 200, "R7 loaded", exp_ocr, 200);

    // R2 dividers
    for (int s = 1; s < 4; s++) begin
      do_reset(s, 0, 100);
      run_n(3 * ratio_of(s) + 5, "R2");
      chk(count == 8'd3, "R2 three ticks", count, 3);
    end

    // R3 run held low
    do_reset(1, 0, 100);
    run_n(21, "R3");
    run = 1'b0;
    run_n(40, "R3");
    chk(count == 8'd2, "R3 held count", count, 2);
    run = 1'b1;
    run_n(40, "R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYC, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule